// File: doc/BRIEF.md
# Periodic Compare-Match Interrupt Timer

This block produces periodic interrupt events for sample timing. It has two counter chains. In each chain a prescale counter divides the clock and advances a free-running counter. Four compare channels watch those free-running counters, and each channel picks one chain as its source. When the chosen counter steps onto a channel's compare value, three things happen:

- the channel's flag is raised;
- the channel adds its programmed step to its compare value;
- the next event is therefore scheduled a fixed number of counts later.

No counter is ever reloaded.

Software reaches the block through a 32-bit word bus. Writes take effect at one clock edge and reads are combinational. Flags are write-one-to-clear, and each flag is gated by an enable bit. Channel 0 has its own interrupt pin. Channels 1 to 3 are merged into one level-sensitive CPU interrupt line, so a handler must clear the flag that fired before that line can assert again for a new event.

Top module: `cit_timer`

## Requirements
- R1: After a synchronous active-low reset every register reads zero and both interrupt outputs are low.
- R2: A started chain's prescale counter (UC0 at 0x10, UC1 at 0x14) increments every clock. When the incremented value reaches its limit (PRE0 at 0x08, PRE1 at 0x0C), the prescale counter wraps to 0. The free-running counter (FRC0 at 0x18, FRC1 at 0x1C) then advances by one. The free-running counter therefore steps once every max(PRE,1) clocks.
- R3: The control register at 0x00 starts chain 0 with bit 0 and chain 1 with bit 1. Writing 0 stops both chains, and their counters then hold their values.
- R4: In the source register at 0x04, bit 4n set makes compare channel n watch chain 1. With that bit clear, channel n watches chain 0. Events on the unselected chain do not affect the channel.
- R5: When channel n's selected free-running counter advances to equal its compare value (CMPn at 0x20+8n), two updates happen at that same edge. Flag n is set, and CMPn is increased by its step (STEPn at 0x24+8n).
- R6: A flag is set on a match whether or not its channel is enabled. A disabled flag drives no output and stays set.
- R7: Flags read at 0x48 with bit n for channel n. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R8: Writing 1s at 0x40 sets enable bits, and writing 1s at 0x44 clears them. Both addresses read the enable mask, with bit n for channel n.
- R9: irq_ch0 is high while flag 0 and enable 0 are both set. irq_cpu is the level OR of the enabled flags of channels 1 to 3. irq_cpu falls when those flags are cleared and rises again only on a new match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational on addr |
| irq_ch0 | output | 1 | Enabled flag of compare channel 0 |
| irq_cpu | output | 1 | Enabled flags of channels 1 to 3, ORed |

## Verification
The bench targets each way the timing or routing could be wrong:

- **Match timing.** The flag must rise on exactly the edge at which the prescaled counter reaches the compare value. A compare that waits one more cycle, or that fires while the counter merely sits at that value, shifts the interrupt by a clock. The second periodic event then lands at the wrong count.
- **Source selection.** A channel is pointed at the slow chain while the fast chain passes its compare value first. A mis-routed select fires early.
- **Flag clearing.** A write of zero to the flag register must leave the flag set. A clear done by plain write instead of write-one-to-clear would drop it.
- **Enable gating.** A flag raised while its channel is disabled must stay invisible until the channel is enabled. A design that gates the setting, rather than the output, would lose that event.
- **Counter arithmetic.** Randomly chosen prescale values and run lengths test the divide and wrap arithmetic against closed-form counts.

// File: rtl/cit_pkg.sv
// Package for the compare-match timer: sizes and the register address map.
// Assumes byte addressing with 32-bit word-aligned registers.
package cit_pkg;
    localparam int ADDR_W    = 8;
    localparam int NUM_CHAIN = 2;
    localparam int NUM_CMP   = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] A_SRCSEL = 8'h04;
    localparam logic [ADDR_W-1:0] A_PRE0   = 8'h08;
    localparam logic [ADDR_W-1:0] A_UC0    = 8'h10;
    localparam logic [ADDR_W-1:0] A_FRC0   = 8'h18;
    localparam logic [ADDR_W-1:0] A_CMP0   = 8'h20;
    localparam logic [ADDR_W-1:0] A_IENSET = 8'h40;
    localparam logic [ADDR_W-1:0] A_IENCLR = 8'h44;
    localparam logic [ADDR_W-1:0] A_FLAG   = 8'h48;

    // Per-chain registers sit 4 bytes apart.
    function automatic logic [ADDR_W-1:0] chain_addr(logic [ADDR_W-1:0] base, int idx);
        return ADDR_W'(int'(base) + 4 * idx);
    endfunction

    // Compare channel n: its compare value at 0x20+8n, its step 4 bytes above.
    function automatic logic [ADDR_W-1:0] cmp_addr(int idx, bit is_step);
        return ADDR_W'(int'(A_CMP0) + 8 * idx + (is_step ? 4 : 0));
    endfunction
endpackage

// File: rtl/cit_chain.sv
// One counter chain: a prescale counter that advances a free-running counter.
// Assumes the limit register reads as "period in clocks", with 0 treated as 1.
// Software writes to any of the three registers take priority over counting.
module cit_chain #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         pre_wr,
    input  logic         uc_wr,
    input  logic         frc_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pre,
    output logic [W-1:0] uc,
    output logic [W-1:0] frc,
    output logic         tick
);
    logic [W:0] uc_inc;

    // Next prescale count, one bit wider so the compare cannot wrap.
    always_comb begin
        uc_inc = {1'b0, uc} + {{W{1'b0}}, 1'b1};
        tick   = run && (uc_inc >= {1'b0, pre});
    end

    // Prescale limit register.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre <= '0;
        else if (pre_wr) pre <= wdata;
    end

    // Prescale counter: counts while running, wraps to 0 on reaching the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)      uc <= '0;
        else if (uc_wr)  uc <= wdata;
        else if (tick)   uc <= '0;
        else if (run)    uc <= uc_inc[W-1:0];
    end

    // Free-running counter: one step per prescale wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      frc <= '0;
        else if (frc_wr) frc <= wdata;
        else if (tick)   frc <= frc + W'(1);
    end

    AST_FRC_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !frc_wr) |=> $stable(frc)); // R3
    AST_FRC_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !frc_wr |=> (frc == $past(frc) || frc == $past(frc) + W'(1))); // R2
endmodule

// File: rtl/cit_cmp.sv
// One compare channel: watches the free-running counter of the selected chain.
// A match is the selected counter stepping onto the compare value. On a match
// the compare value grows by the step. A software write to the compare value
// wins over that update.
module cit_cmp #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic [W-1:0] frc0,
    input  logic [W-1:0] frc1,
    input  logic         tick0,
    input  logic         tick1,
    input  logic         cmp_wr,
    input  logic         step_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cmp,
    output logic [W-1:0] step,
    output logic         match
);
    logic [W-1:0] src_frc;
    logic         src_tick;

    // Pick the source chain and detect the counter arriving at the compare value.
    always_comb begin
        src_frc  = sel ? frc1  : frc0;
        src_tick = sel ? tick1 : tick0;
        match    = src_tick && ((src_frc + W'(1)) == cmp);
    end

    // Compare register: software load, or self-increment by the step on a match.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp <= '0;
        else if (cmp_wr) cmp <= wdata;
        else if (match)  cmp <= cmp + step;
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n)       step <= '0;
        else if (step_wr) step <= wdata;
    end

    AST_STEP_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !cmp_wr) |=> (cmp == $past(cmp) + $past(step))); // R5
    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && !cmp_wr) |=> $stable(cmp)); // R5
endmodule

// File: rtl/cit_timer.sv
// Top of the compare-match timer: register decode, run control, source
// selection, enables, write-one-to-clear flags and the two interrupt outputs.
// Assumes one write per cycle and a combinational read path. If a match and a
// clearing write hit the same flag in the same cycle, the match wins.
module cit_timer
    import cit_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic              irq_ch0,
    output logic              irq_cpu
);
    localparam int SEL_STRIDE = 4;

    logic [NUM_CHAIN-1:0] run_q;
    logic [NUM_CHAIN-1:0] tick;
    logic [NUM_CMP-1:0]   sel_q;
    logic [NUM_CMP-1:0]   ien_q;
    logic [NUM_CMP-1:0]   flag_q;
    logic [NUM_CMP-1:0]   match;
    logic [W-1:0]         pre  [NUM_CHAIN];
    logic [W-1:0]         uc   [NUM_CHAIN];
    logic [W-1:0]         frc  [NUM_CHAIN];
    logic [W-1:0]         cmp  [NUM_CMP];
    logic [W-1:0]         step [NUM_CMP];

    logic wr_flag;
    assign wr_flag = wr_en && (addr == A_FLAG);

    for (genvar g = 0; g < NUM_CHAIN; g++) begin : g_chain
        cit_chain #(.W(W)) u_chain (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_q[g]),
            .pre_wr (wr_en && addr == chain_addr(A_PRE0, g)),
            .uc_wr  (wr_en && addr == chain_addr(A_UC0, g)),
            .frc_wr (wr_en && addr == chain_addr(A_FRC0, g)),
            .wdata  (wdata),
            .pre    (pre[g]),
            .uc     (uc[g]),
            .frc    (frc[g]),
            .tick   (tick[g])
        );
    end

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        cit_cmp #(.W(W)) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (sel_q[c]),
            .frc0    (frc[0]),
            .frc1    (frc[1]),
            .tick0   (tick[0]),
            .tick1   (tick[1]),
            .cmp_wr  (wr_en && addr == cmp_addr(c, 1'b0)),
            .step_wr (wr_en && addr == cmp_addr(c, 1'b1)),
            .wdata   (wdata),
            .cmp     (cmp[c]),
            .step    (step[c]),
            .match   (match[c])
        );

        AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            match[c] |=> flag_q[c]); // R5
    end

    // Run control and source selection registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            sel_q <= '0;
        end else if (wr_en && addr == A_CTRL) begin
            run_q <= wdata[NUM_CHAIN-1:0];
        end else if (wr_en && addr == A_SRCSEL) begin
            for (int n = 0; n < NUM_CMP; n++) sel_q[n] <= wdata[SEL_STRIDE*n];
        end
    end

    // Interrupt enables: separate set and clear addresses, write 1 to act.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ien_q <= '0;
        else if (wr_en && addr == A_IENSET) ien_q <= ien_q | wdata[NUM_CMP-1:0];
        else if (wr_en && addr == A_IENCLR) ien_q <= ien_q & ~wdata[NUM_CMP-1:0];
    end

    // Flags: set by a match, cleared by writing 1. Match takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            for (int n = 0; n < NUM_CMP; n++) begin
                if (match[n])                     flag_q[n] <= 1'b1;
                else if (wr_flag && wdata[n])     flag_q[n] <= 1'b0;
            end
        end
    end

    // Interrupt outputs: channel 0 alone, channels 1 to 3 merged.
    always_comb begin
        irq_ch0 = flag_q[0] & ien_q[0];
        irq_cpu = |(flag_q[NUM_CMP-1:1] & ien_q[NUM_CMP-1:1]);
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[NUM_CHAIN-1:0] = run_q;
        end else if (addr == A_SRCSEL) begin
            for (int n = 0; n < NUM_CMP; n++) rdata[SEL_STRIDE*n] = sel_q[n];
        end else if (addr == A_IENSET || addr == A_IENCLR) begin
            rdata[NUM_CMP-1:0] = ien_q;
        end else if (addr == A_FLAG) begin
            rdata[NUM_CMP-1:0] = flag_q;
        end else begin
            for (int g = 0; g < NUM_CHAIN; g++) begin
                if (addr == chain_addr(A_PRE0, g)) rdata = pre[g];
                if (addr == chain_addr(A_UC0, g))  rdata = uc[g];
                if (addr == chain_addr(A_FRC0, g)) rdata = frc[g];
            end
            for (int n = 0; n < NUM_CMP; n++) begin
                if (addr == cmp_addr(n, 1'b0)) rdata = cmp[n];
                if (addr == cmp_addr(n, 1'b1)) rdata = step[n];
            end
        end
    end

    AST_FLAG_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R7
    AST_IEN_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_IENSET) |=>
        ((ien_q & $past(wdata[NUM_CMP-1:0])) == $past(wdata[NUM_CMP-1:0]))); // R8
    AST_CPU_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_cpu) |-> $past(wr_en && (addr == A_FLAG || addr == A_IENCLR))); // R9
endmodule

// File: tb/cit_timer_tb.sv
`timescale 1ns/1ps
module cit_timer_tb;
    localparam logic [7:0] CTRL = 8'h00, SRCSEL = 8'h04, PRE0 = 8'h08, PRE1 = 8'h0C;
    localparam logic [7:0] UC0 = 8'h10, UC1 = 8'h14, FRC0 = 8'h18, FRC1 = 8'h1C;
    localparam logic [7:0] IENSET = 8'h40, IENCLR = 8'h44, FLAG = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_ch0, irq_cpu;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cit_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_ch0(irq_ch0), .irq_cpu(irq_cpu)
    );

    function automatic logic [7:0] cmp_a(int n);  return 8'(32 + 8 * n); endfunction
    function automatic logic [7:0] step_a(int n); return 8'(36 + 8 * n); endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));

        // R1: reset state
        do_reset();
        foreach (v[i]) begin end
        for (int a = 0; a <= 8'h48; a += 4) begin
            rd(8'(a), v);
            chk("R1 register zero after reset", v, 32'h0);
        end
        chk("R1 irq_ch0 low", {31'h0, irq_ch0}, 32'h0);
        chk("R1 irq_cpu low", {31'h0, irq_cpu}, 32'h0);

        // R2, R3: prescaled counting, then stop and hold
        do_reset();
        wr(PRE0, 32'd5);
        wr(CTRL, 32'h1);
        wait_n(23);
        rd(FRC0, v); chk("R2 FRC0 after 23 clocks /5", v, 32'd4);
        rd(UC0, v);  chk("R2 UC0 after 23 clocks /5", v, 32'd3);
        wr(CTRL, 32'h0);
        wait_n(10);
        rd(FRC0, v); chk("R3 FRC0 holds after stop", v, 32'd5);
        rd(UC0, v);  chk("R3 UC0 holds after stop", v, 32'd0);
        rd(CTRL, v); chk("R3 control reads stopped", v, 32'd0);

        // R2, R3: random prescale values and run lengths on chain 1
        for (int it = 0; it < 8; it++) begin
            int p, m;
            p = 1 + int'($urandom % 7);
            m = int'($urandom % 50);
            do_reset();
            wr(PRE1, 32'(p));
            wr(CTRL, 32'h2);
            wait_n(m);
            rd(FRC1, v); chk("R2 random FRC1", v, 32'(m / p));
            rd(UC1, v);  chk("R2 random UC1", v, 32'(m % p));
            rd(FRC0, v); chk("R3 unstarted chain 0 idle", v, 32'd0);
        end

        // R5, R7, R9: periodic channel 0, prescale 3, compare 4, step 2
        do_reset();
        wr(PRE0, 32'd3);
        wr(cmp_a(0), 32'd4);
        wr(step_a(0), 32'd2);
        wr(IENSET, 32'h1);
        wr(CTRL, 32'h1);
        wait_n(11);
        chk("R5 no event before counter reaches 4", {31'h0, irq_ch0}, 32'h0);
        wait_n(1);
        chk("R9 irq_ch0 on first match", {31'h0, irq_ch0}, 32'h1);
        chk("R9 channel 0 not on cpu line", {31'h0, irq_cpu}, 32'h0);
        rd(cmp_a(0), v); chk("R5 compare advanced by step", v, 32'd6);
        wr(FLAG, 32'h0);
        rd(FLAG, v); chk("R7 writing 0 leaves flag set", v, 32'h1);
        wr(FLAG, 32'h1);
        rd(FLAG, v); chk("R7 writing 1 clears flag", v, 32'h0);
        chk("R9 irq_ch0 low after clear", {31'h0, irq_ch0}, 32'h0);
        wait_n(2);
        chk("R5 second periodic event", {31'h0, irq_ch0}, 32'h1);
        rd(cmp_a(0), v); chk("R5 compare advanced again", v, 32'd8);

        // R4: channel 1 on slow chain 1 while fast chain 0 passes the value first
        do_reset();
        wr(PRE0, 32'd1);
        wr(PRE1, 32'd4);
        wr(SRCSEL, 32'h10);
        wr(cmp_a(1), 32'd3);
        wr(step_a(1), 32'd100);
        wr(IENSET, 32'h2);
        wr(CTRL, 32'h3);
        wait_n(10);
        chk("R4 chain 0 passing 3 ignored", {31'h0, irq_cpu}, 32'h0);
        wait_n(2);
        chk("R4 fires from chain 1", {31'h0, irq_cpu}, 32'h1);
        rd(cmp_a(1), v); chk("R4 compare stepped", v, 32'd103);
        rd(SRCSEL, v);   chk("R4 source register readback", v, 32'h10);

        // R6, R8, R9: disabled channel 2 on chain 0, prescale 1, compare 5, step 10
        do_reset();
        wr(PRE0, 32'd1);
        wr(cmp_a(2), 32'd5);
        wr(step_a(2), 32'd10);
        wr(CTRL, 32'h1);
        wait_n(6);
        rd(FLAG, v); chk("R6 flag sets while disabled", v, 32'h4);
        chk("R6 disabled flag drives nothing", {31'h0, irq_cpu}, 32'h0);
        wr(IENSET, 32'h4);
        chk("R9 cpu line after enabling", {31'h0, irq_cpu}, 32'h1);
        chk("R9 irq_ch0 unaffected by channel 2", {31'h0, irq_ch0}, 32'h0);
        rd(IENSET, v); chk("R8 enable mask set", v, 32'h4);
        wr(FLAG, 32'h4);
        chk("R9 cpu line falls after clear", {31'h0, irq_cpu}, 32'h0);
        wait_n(4);
        chk("R9 no refire before next match", {31'h0, irq_cpu}, 32'h0);
        wait_n(1);
        chk("R9 refires on next match", {31'h0, irq_cpu}, 32'h1);
        wr(IENCLR, 32'h4);
        chk("R8 clear enable drops line", {31'h0, irq_cpu}, 32'h0);
        rd(IENCLR, v); chk("R8 enable mask cleared", v, 32'h0);
        rd(FLAG, v);   chk("R6 flag kept while disabled", v, 32'h4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule